// File: doc/BRIEF.md
# Control-Flow Resolution Unit

This unit settles every control-transfer instruction in one place. An issuing stage presents the current program counter, both source operand values, an immediate offset that is already sign-extended, and a 3-bit operation code. One clock later the unit returns a registered result. The result says whether the fetch path must be redirected and gives the address to fetch next. For jump operations it also gives the return address to write back, with a write-enable.

Conditional branches compare the two operands with equality, signed ordering or unsigned ordering. Jump-and-link is relative to the program counter. Register-indirect jump-and-link adds the offset to the first operand and clears the lowest address bit. A subroutine call is a jump-and-link whose destination is the return-address register, so the link value is the program counter plus 4. A return is a register-indirect jump through that register with offset 0. Derived forms are not handled here; the decoder produces them by swapping operands or by feeding a zero operand. Every instruction is 4 bytes long.

Top module: `cf_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_taken` and `out_link_we` go to 0, and `out_next_pc` and `out_link_val` go to zero.
- R2: Every accepted request (`in_valid` high at a rising edge) produces exactly one result with `out_valid` high after that same edge. The results come out in request order, with a latency of one cycle.
- R3: For a branch, `out_next_pc` is `in_pc + in_imm` when the condition holds, and `in_pc + 4` when it does not. `out_taken` equals the condition.
- R4: Op code 0 branches when the operands are equal. Op code 1 branches when they differ.
- R5: Op code 2 branches when operand 1 is less than operand 2, both read as two's complement. Op code 3 branches when operand 1 is greater than or equal to operand 2, also as two's complement.
- R6: Op code 4 branches when operand 1 is less than operand 2, both read as unsigned. Op code 5 branches when operand 1 is greater than or equal to operand 2, also as unsigned.
- R7: Op code 6 (jump-and-link) always sets `out_taken` and `out_link_we`, sets `out_next_pc` to `in_pc + in_imm`, and sets `out_link_val` to `in_pc + 4`. This covers a call through the return-address register.
- R8: Op code 7 (register-indirect jump-and-link) always sets `out_taken` and `out_link_we`, sets `out_next_pc` to `(in_rs1 + in_imm)` with bit 0 cleared, and sets `out_link_val` to `in_pc + 4`. This covers a return with offset 0.
- R9: For branch op codes 0 to 5, `out_link_we` is 0 and `out_link_val` is zero.
- R10: In a cycle with `out_valid` low, `out_taken` and `out_link_we` are 0.
- R11: All additions wrap modulo 2^XLEN, so a negative offset moves the target backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_op | input | 3 | Operation code (0 eq, 1 ne, 2 lt, 3 ge, 4 ltu, 5 geu, 6 jal, 7 jalr) |
| in_pc | input | XLEN | Program counter of the instruction |
| in_rs1 | input | XLEN | First source operand |
| in_rs2 | input | XLEN | Second source operand |
| in_imm | input | XLEN | Sign-extended offset |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Redirect required |
| out_next_pc | output | XLEN | Next fetch address |
| out_link_we | output | 1 | Link write-enable |
| out_link_val | output | XLEN | Return address to write |

## Verification
The assertions assume that `in_op` always carries one of the eight defined codes when `in_valid` is high. They also assume that inputs are held stable from one falling edge to the next, so that each request is sampled once. The stimulus drives only defined codes and changes inputs only at falling edges. It drops `in_valid` between bursts, so idle results are seen as well. Operand pairs are often made equal, or given opposite signs, so that the signed and unsigned comparisons disagree and the equality cases are reached.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [2:0] {
    OP_BEQ  = 3'd0,
    OP_BNE  = 3'd1,
    OP_BLT  = 3'd2,
    OP_BGE  = 3'd3,
    OP_BLTU = 3'd4,
    OP_BGEU = 3'd5,
    OP_JAL  = 3'd6,
    OP_JALR = 3'd7
  } cf_op_e;

  localparam int unsigned OP_W = 3;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } cmp_flags_t;
endpackage

// File: rtl/cf_compare.sv
module cf_compare #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output cf_pkg::cmp_flags_t flags
);
  always_comb begin
    flags.eq   = (a == b);
    flags.lt_s = ($signed(a) < $signed(b));
    flags.lt_u = (a < b);
  end
endmodule

// File: rtl/cf_decide.sv
module cf_decide (
  input  logic [cf_pkg::OP_W-1:0] op,
  input  cf_pkg::cmp_flags_t      flags,
  output logic                    is_jump,
  output logic                    redirect
);
  import cf_pkg::*;
  logic cond;

  always_comb begin
    unique case (cf_op_e'(op))
      OP_BEQ:  cond = flags.eq;
      OP_BNE:  cond = !flags.eq;
      OP_BLT:  cond = flags.lt_s;
      OP_BGE:  cond = !flags.lt_s;
      OP_BLTU: cond = flags.lt_u;
      OP_BGEU: cond = !flags.lt_u;
      default: cond = 1'b1;
    endcase
    is_jump  = (op == OP_JAL) || (op == OP_JALR);
    redirect = cond;
  end
endmodule

// File: rtl/cf_target.sv
module cf_target #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned INSN_LEN  = 4,
  parameter bit          ALIGN_IND = 1'b1
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] rel_pc,
  output logic [XLEN-1:0] ind_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_LEN);
  logic [XLEN-1:0] ind_sum;

  always_comb begin
    seq_pc  = pc + STEP;
    rel_pc  = pc + imm;
    ind_sum = base + imm;
  end

  generate
    if (ALIGN_IND) begin : g_align
      assign ind_pc = {ind_sum[XLEN-1:1], 1'b0};
    end else begin : g_raw
      assign ind_pc = ind_sum;
    end
  endgenerate
endmodule

// File: rtl/cf_resolve.sv
module cf_resolve #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned INSN_LEN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      in_op,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [XLEN-1:0] in_imm,
  output logic            out_valid,
  output logic            out_taken,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_link_we,
  output logic [XLEN-1:0] out_link_val
);
  import cf_pkg::*;

  cmp_flags_t      flags;
  logic            is_jump, redirect;
  logic [XLEN-1:0] seq_pc, rel_pc, ind_pc, nxt;

  cf_compare #(.XLEN(XLEN)) u_cmp (
    .a(in_rs1), .b(in_rs2), .flags(flags)
  );

  cf_decide u_dec (
    .op(in_op), .flags(flags), .is_jump(is_jump), .redirect(redirect)
  );

  cf_target #(.XLEN(XLEN), .INSN_LEN(INSN_LEN), .ALIGN_IND(1'b1)) u_tgt (
    .pc(in_pc), .base(in_rs1), .imm(in_imm),
    .seq_pc(seq_pc), .rel_pc(rel_pc), .ind_pc(ind_pc)
  );

  always_comb begin
    if (in_op == OP_JALR)  nxt = ind_pc;
    else if (redirect)     nxt = rel_pc;
    else                   nxt = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_next_pc  <= '0;
      out_link_we  <= 1'b0;
      out_link_val <= '0;
    end else begin
      out_valid    <= in_valid;
      out_taken    <= in_valid && redirect;
      out_next_pc  <= in_valid ? nxt : '0;
      out_link_we  <= in_valid && is_jump;
      out_link_val <= (in_valid && is_jump) ? seq_pc : '0;
    end
  end

  // Assertions
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_branch_target_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op <= 3'd5) |=>
      (out_next_pc == $past(in_pc) + XLEN'(INSN_LEN)) ||
      (out_next_pc == $past(in_pc) + $past(in_imm)));
  assert_jump_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 3'd6) |=> (out_taken && out_link_we &&
      out_link_val == $past(in_pc) + XLEN'(INSN_LEN)));
  assert_ind_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd7) |=> (out_next_pc[0] == 1'b0));
  assert_branch_no_link_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op <= 3'd5) |=> (!out_link_we && out_link_val == '0));
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_taken && !out_link_we));
endmodule

// File: tb/cf_resolve_tb_top.sv
module cf_resolve_tb_top;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_op = '0;
  logic [XL-1:0] in_pc = '0, in_rs1 = '0, in_rs2 = '0, in_imm = '0;
  logic          out_valid, out_taken, out_link_we;
  logic [XL-1:0] out_next_pc, out_link_val;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic          taken;
    logic [XL-1:0] npc;
    logic          we;
    logic [XL-1:0] link;
    string         tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  cf_resolve #(.XLEN(XL), .INSN_LEN(4)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_pc(in_pc), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm),
    .out_valid(out_valid), .out_taken(out_taken), .out_next_pc(out_next_pc),
    .out_link_we(out_link_we), .out_link_val(out_link_val)
  );

  function automatic exp_t model(input logic [2:0] op, input logic [XL-1:0] pc,
                                 input logic [XL-1:0] a, input logic [XL-1:0] b,
                                 input logic [XL-1:0] imm, input string tag);
    exp_t e;
    logic c;
    logic [XL-1:0] s;
    e.tag = tag;
    case (op)
      3'd0: c = (a == b);
      3'd1: c = (a != b);
      3'd2: c = ($signed(a) < $signed(b));
      3'd3: c = ($signed(a) >= $signed(b));
      3'd4: c = (a < b);
      3'd5: c = (a >= b);
      default: c = 1'b1;
    endcase
    e.taken = c;
    if (op == 3'd7) begin
      s = a + imm;
      s[0] = 1'b0;
      e.npc = s;
    end else begin
      e.npc = c ? pc + imm : pc + 32'd4;
    end
    e.we   = (op >= 3'd6);
    e.link = e.we ? pc + 32'd4 : '0;
    return e;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [XL-1:0] act, input logic [XL-1:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic drive(input logic [2:0] op, input logic [XL-1:0] pc,
                       input logic [XL-1:0] a, input logic [XL-1:0] b,
                       input logic [XL-1:0] imm, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_pc = pc; in_rs1 = a; in_rs2 = b; in_imm = imm;
    sb.push_back(model(op, pc, a, b, imm, tag));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op = $urandom;
      in_rs1 = $urandom;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && !finished) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            checks++;
            fail_line("R2", "unexpected result", 32'd1, 32'd0);
          end else begin
            exp_t e;
            logic bad;
            e = sb.pop_front();
            checks++;
            bad = 1'b0;
            if (out_taken !== e.taken) begin
              fail_line(e.tag, "taken", 32'(out_taken), 32'(e.taken)); bad = 1'b1;
            end
            if (!bad && out_next_pc !== e.npc) begin
              fail_line(e.tag, "next_pc", out_next_pc, e.npc); bad = 1'b1;
            end
            if (!bad && out_link_we !== e.we) begin
              fail_line(e.tag, "link_we", 32'(out_link_we), 32'(e.we)); bad = 1'b1;
            end
            if (!bad && out_link_val !== e.link)
              fail_line(e.tag, "link_val", out_link_val, e.link);
          end
        end else begin
          checks++;
          if (out_taken !== 1'b0 || out_link_we !== 1'b0)
            fail_line("R10", "idle taken/we", {30'd0, out_taken, out_link_we}, 32'd0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; in_op = 3'd6;  // request during reset must be discarded
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid !== 1'b0 || out_taken !== 1'b0 || out_link_we !== 1'b0 ||
        out_next_pc !== '0 || out_link_val !== '0)
      fail_line("R1", "reset outputs", {29'd0, out_valid, out_taken, out_link_we}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    idle(2);

    // R4 equality
    drive(3'd0, 32'h1000, 32'h55, 32'h55, 32'h40, "R4");
    drive(3'd0, 32'h1000, 32'h55, 32'h56, 32'h40, "R4");
    drive(3'd1, 32'h2000, 32'h7, 32'h8, 32'h20, "R4");
    drive(3'd1, 32'h2000, 32'h7, 32'h7, 32'h20, "R4");
    idle(1);
    // R5 signed: -1 < 1
    drive(3'd2, 32'h3000, 32'hFFFF_FFFF, 32'h1, 32'h10, "R5");
    drive(3'd3, 32'h3000, 32'hFFFF_FFFF, 32'h1, 32'h10, "R5");
    drive(3'd3, 32'h3000, 32'h9, 32'h9, 32'h10, "R5");
    // R6 unsigned: 0xFFFFFFFF is large
    drive(3'd4, 32'h4000, 32'hFFFF_FFFF, 32'h1, 32'h10, "R6");
    drive(3'd5, 32'h4000, 32'hFFFF_FFFF, 32'h1, 32'h10, "R6");
    drive(3'd4, 32'h4000, 32'h3, 32'h3, 32'h10, "R6");
    // R3 / R11 negative offset, taken and not taken
    drive(3'd0, 32'h5000, 32'h1, 32'h1, 32'hFFFF_FFF0, "R11");
    drive(3'd2, 32'h5000, 32'h5, 32'h1, 32'hFFFF_FFF0, "R3");
    idle(2);
    // R7 call: link is pc+4
    drive(3'd6, 32'h6000, 32'h0, 32'h0, 32'h0000_0100, "R7");
    drive(3'd6, 32'h0000_0004, 32'h0, 32'h0, 32'hFFFF_FFF8, "R11");
    // R8 indirect with odd sum, and return via offset 0
    drive(3'd7, 32'h7000, 32'h0000_8001, 32'h0, 32'h4, "R8");
    drive(3'd7, 32'h7100, 32'h0000_6004, 32'h0, 32'h0, "R8");
    drive(3'd7, 32'h7200, 32'h0000_9000, 32'h0, 32'hFFFF_FFFF, "R8");
    // R9 branch link stays zero
    drive(3'd5, 32'h8000, 32'h2, 32'h1, 32'h8, "R9");
    idle(3);

    // randomized burst (R2 ordering)
    for (int i = 0; i < 300; i++) begin
      logic [XL-1:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 4) == 0) b = ~a;
      drive(3'($urandom_range(0, 7)), $urandom, a, b, $urandom, "R2");
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb.size() != 0) fail_line("R2", "results missing", sb.size(), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule